// File: doc/BRIEF.md
# Deferred-Update Timer Tick Prescaler

This block divides the system clock down to a one-cycle tick enable that advances a main timer counter. The division ratio comes from one of two sources. In fine mode a software-written select register gives any whole ratio from 1 to 256. In coarse mode a small exponent input gives a power-of-two ratio from 1 to 128.

Changing the select value, the exponent or the mode never disturbs the period already in progress. The requested ratio is only copied into the running divider when its counter wraps through zero. It is also copied while the timer is disabled, when the counter is held at zero. Software can therefore retune the timer at any moment without producing a short or long tick interval.

The register reads back the value most recently written, whether or not the divider has applied it yet. The reset input is asynchronous and active-low, and its release is synchronised to the clock inside the block.

Top module: `tmr_tick_prescaler`

## Requirements
- R1: After reset the select register reads 0, the divide counter is at zero and the running ratio is 1.
- R2: A write stores `wr_data` in the select register. From the next cycle `rd_data` returns the last written value, even while the divider still runs with an older ratio.
- R3: With `fine_en` = 1 and a running select value S, `tick` pulses once every S+1 enabled cycles. S = 0 gives a tick on every enabled cycle.
- R4: With `fine_en` = 0 and `coarse_sel` = k, `tick` pulses once every 2^k enabled cycles. The select register has no effect on the ratio in this mode.
- R5: A change of select value, exponent or mode is applied only when the divide counter wraps to zero after a tick, or while `run_en` is low. The period in progress keeps its original length.
- R6: `tick` is high for exactly one cycle per period, and only in a cycle where `run_en` is high. After a tick the counter restarts at zero.
- R7: While `run_en` is low the counter holds at zero. Once `run_en` rises, the first tick comes after a full period of the requested ratio, i.e. in the ratio-th enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | SEL_W (8) | Select value to store |
| rd_data | output | SEL_W (8) | Last written select value |
| fine_en | input | 1 | 1 selects the fine ratio, 0 the power-of-two ratio |
| coarse_sel | input | CSEL_W (3) | Exponent k of the coarse ratio 2^k |
| run_en | input | 1 | Timer enable; low holds the divider at zero |
| tick | output | 1 | One-cycle enable to the timer counter |

## Verification
The bench builds the block with its defaults, an 8-bit select and a 3-bit exponent. With these values every fine ratio from 1 to 256 and every coarse ratio from 1 to 128 is reachable, while the longest period still fits many times into a short run.

Random select values are biased toward small numbers so that wraps, and therefore deferred updates, occur often. They are mixed with mode flips and enable drops at random points in a period. Directed sequences then measure tick intervals around a mid-period write and around an enable rise, so that the no-glitch rule is checked in cycles rather than only through the reference model.

// File: rtl/prs_pkg.sv
package prs_pkg;

  // Source of the requested ratio.
  typedef enum logic [0:0] {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } prs_mode_e;

  // Divider events for one cycle.
  typedef struct packed {
    logic hold;   // timer disabled, counter parked at zero
    logic wrap;   // terminal count reached, tick issued
  } prs_evt_t;

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/prs_sel_reg.sv
module prs_sel_reg #(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q
);
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_en) sel_q <= sel_d;
  end

  // R2: stored value equals the last write
  p_rd_follows_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == $past(wr_data)));

  // R2: without a write the register keeps its value
  p_sel_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/prs_ratio_sel.sv
module prs_ratio_sel
  import prs_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int CSEL_W = 3,
  parameter int CNT_W  = 8
) (
  input  prs_mode_e         mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CSEL_W-1:0] coarse_sel,
  output logic [CNT_W-1:0]  req_term
);
  logic [CNT_W-1:0] fine_term;
  logic [CNT_W-1:0] coarse_term;

  generate
    if (CNT_W > SEL_W) begin : g_fine_ext
      assign fine_term = {{(CNT_W-SEL_W){1'b0}}, sel};
    end else begin : g_fine_eq
      assign fine_term = sel;
    end
  endgenerate

  // 2^k - 1: ones below bit k
  always_comb begin
    coarse_term = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(coarse_sel)) coarse_term[b] = 1'b1;
    end
  end

  always_comb begin
    case (mode)
      MODE_FINE: req_term = fine_term;
      default:   req_term = coarse_term;
    endcase
  end

  logic [CNT_W:0] term_p1;
  assign term_p1 = {1'b0, req_term} + {{CNT_W{1'b0}}, 1'b1};

  // R4: the coarse ratio is always a power of two
  always_comb begin
    if (mode == MODE_COARSE) begin
      p_coarse_pow2_r4: assert ($countones(term_p1) == 1);
    end
  end
endmodule

// File: rtl/prs_count.sv
module prs_count
  import prs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] req_term,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_q;
  logic             term_ld;
  prs_evt_t         evt;

  always_comb begin
    evt.hold = !run_en;
    evt.wrap = run_en && (cnt_q == term_q);
    term_ld  = evt.hold || evt.wrap;
    if (term_ld) cnt_d = '0;
    else         cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Active ratio reloads only at the zero point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       term_q <= '0;
    else if (term_ld) term_q <= req_term;
  end

  assign tick = evt.wrap;

  // R5: running ratio frozen inside a period
  p_term_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> $stable(term_q));

  // R7: disabled timer parks the counter at zero
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0));

  // R6: counter restarts after each tick
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // R3: counter never passes the terminal value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);
endmodule

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler
  import prs_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int CSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_data,
  output logic [SEL_W-1:0]  rd_data,
  input  logic              fine_en,
  input  logic [CSEL_W-1:0] coarse_sel,
  input  logic              run_en,
  output logic              tick
);
  localparam int COARSE_MAX = (1 << CSEL_W) - 1;
  localparam int CNT_W      = (SEL_W > COARSE_MAX) ? SEL_W : COARSE_MAX;

  logic             rst_n_s;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] req_term;
  prs_mode_e        mode;

  assign mode = fine_en ? MODE_FINE : MODE_COARSE;

  prs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  prs_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sel_q   (sel_q)
  );

  prs_ratio_sel #(.SEL_W(SEL_W), .CSEL_W(CSEL_W), .CNT_W(CNT_W)) u_ratio (
    .mode       (mode),
    .sel        (sel_q),
    .coarse_sel (coarse_sel),
    .req_term   (req_term)
  );

  prs_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run_en   (run_en),
    .req_term (req_term),
    .tick     (tick)
  );

  assign rd_data = sel_q;

  // R6: a tick never appears in two adjacent cycles unless the ratio is 1
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick && req_term != '0) |=> !tick || $past(u_cnt.term_q == '0) || (u_cnt.term_q == '0));
endmodule

// File: tb/tb_tmr_tick_prescaler.sv
`timescale 1ns/1ps
module tb_tmr_tick_prescaler;
  localparam int SEL_W  = 8;
  localparam int CSEL_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_data;
  logic [SEL_W-1:0]  rd_data;
  logic              fine_en;
  logic [CSEL_W-1:0] coarse_sel;
  logic              run_en;
  logic              tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  int m_sel, m_cnt, m_term;

  tmr_tick_prescaler #(.SEL_W(SEL_W), .CSEL_W(CSEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fine_en(fine_en), .coarse_sel(coarse_sel),
    .run_en(run_en), .tick(tick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int req_term(input int sel, input bit fine, input int k);
    if (fine) return sel;
    return (1 << k) - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One cycle: drive at negedge, compare, advance the model.
  task automatic step(input bit wr, input int data, input bit fine, input int k,
                      input bit run, output bit t);
    int exp_t;
    @(negedge clk);
    wr_en = wr; wr_data = data[SEL_W-1:0]; fine_en = fine;
    coarse_sel = k[CSEL_W-1:0]; run_en = run;
    #1;
    exp_t = (run && m_cnt == m_term) ? 1 : 0;
    chk(fine ? "R3/R6" : "R4/R6", int'(tick), exp_t, "tick");
    chk("R2", int'(rd_data), m_sel, "rd_data");
    t = tick;
    if (!run || m_cnt == m_term) begin
      m_cnt = 0;
      m_term = req_term(m_sel, fine, k);
    end else begin
      m_cnt++;
    end
    if (wr) m_sel = data & ((1 << SEL_W) - 1);
  endtask

  // Cycles until the next tick, counting the tick cycle itself.
  task automatic measure(input bit fine, input int k, output int n);
    bit t;
    n = 0;
    do begin
      step(0, 0, fine, k, 1, t);
      n++;
    end while (!t && n < 600);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit t;
    int n, data, k;
    bit fine, run, wr;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 0; wr_data = '0; fine_en = 1; coarse_sel = '0; run_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_sel = 0; m_cnt = 0; m_term = 0;

    // R1: reset state
    #1;
    chk("R1", int'(rd_data), 0, "rd_data after reset");
    chk("R1", int'(tick), 0, "tick while disabled");
    // R1: running ratio 1 straight after reset
    step(0, 0, 1, 0, 1, t);
    chk("R1", int'(t), 1, "first enabled cycle ticks");
    step(0, 0, 1, 0, 1, t);
    chk("R1", int'(t), 1, "ratio 1 ticks every cycle");

    // R7: enable rise gives a full first period
    step(1, 9, 1, 0, 0, t);
    step(0, 0, 1, 0, 0, t);
    measure(1, 0, n);
    chk("R7", n, 10, "first period after enable");
    // R5: write mid-period does not alter current period
    repeat (4) step(0, 0, 1, 0, 1, t);
    step(1, 2, 1, 0, 1, t);
    chk("R2", int'(rd_data), 9, "read before write lands");
    measure(1, 0, n);
    chk("R5", n + 5, 10, "period with mid-period write");
    chk("R2", int'(rd_data), 2, "read returns new value");
    measure(1, 0, n);
    chk("R3", n, 3, "new ratio after wrap");
    // R3: maximum fine ratio
    step(1, 255, 1, 0, 1, t);
    measure(1, 0, n);
    measure(1, 0, n);
    chk("R3", n, 256, "ratio 256");
    // R4: coarse mode ignores select; mode change deferred
    step(0, 0, 0, 3, 1, t);
    measure(0, 3, n);
    measure(0, 3, n);
    chk("R4", n, 8, "coarse 2^3");
    step(1, 5, 0, 3, 1, t);
    measure(0, 3, n);
    measure(0, 3, n);
    chk("R4", n, 8, "select write ignored in coarse");
    measure(0, 7, n);
    measure(0, 7, n);
    chk("R4", n, 128, "coarse 2^7");
    // R7: disabled timer never ticks
    repeat (5) begin
      step(0, 0, 1, 0, 0, t);
      chk("R7", int'(t), 0, "no tick while disabled");
    end

    // Random mix
    fine = 1; k = 0;
    for (int i = 0; i < 6000; i++) begin
      wr = ($urandom % 16) == 0;
      data = ($urandom % 2) ? ($urandom % 8) : ($urandom % 256);
      if (($urandom % 64) == 0) fine = ~fine;
      if (($urandom % 48) == 0) k = $urandom % 8;
      run = ($urandom % 32) != 0;
      step(wr, data, fine, k, run, t);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule